// File: doc/BRIEF.md
# Register Write Address/Data Port

This block sits between a small sequencing controller and the register space of a larger device. The controller writes two special destinations: an address destination that latches a target, and a data destination that turns each value into a write at that target. The latched address then advances on its own, so a run of consecutive registers can be filled with back-to-back data writes. When bit 18 of the latched address is set, the address stays put, so one register can be written repeatedly.

The address can be latched in two ways. A privileged write trusts the value. A user write compares it against a fixed protection table; a miss raises a fault and the port refuses data until the next address write. A nonzero top byte selects a separate pipe register space. Writes to that space go out on their own handshaken bus and stall the controller until the far side reports completion. Some pipe codes carry no payload and fire as soon as their address is written.

Top module: `regwr_port`

## Requirements
- R1: While reset is held, `reg_wr_valid`, `pipe_req`, `prot_fault` and `stall` are all low.
- R2: An accepted address write with `addr_chk` low latches `addr_wdata` without any table check and clears `prot_fault` from the next cycle.
- R3: An accepted address write with `addr_chk` high is checked against four entries (base/mask: 0x00001000/0xFFFFF000, 0x00008000/0xFFFFFF00, 0x00042000/0xFFFFFF00, 0xA0000000/0xFF000000), and an entry hits when `(addr & mask) == base`. On a miss, `prot_fault` is high from the next cycle until the next accepted address write, and every data write in between is dropped with no output and no address change.
- R4: A data write to a register-space address (top byte zero) pulses `reg_wr_valid` one cycle later, with `reg_wr_addr` equal to address bits [17:0] and `reg_wr_data` equal to the data. Bits [17:0] then increase by one, wrapping from 0x3FFFF to 0, and the upper bits are left unchanged.
- R5: When bit 18 of the latched address is set, data writes leave the address unchanged, in both register and pipe space.
- R6: When an address write and a data write are accepted in the same cycle, the data write uses the new address.
- R7: A data write before any address write since reset produces no register write and no pipe write.
- R8: A data write to a pipe-space address (top byte nonzero, not a no-data code) raises `pipe_req` one cycle later, with `pipe_code` equal to the top byte and `pipe_data` equal to the data. The top byte then increases by one, and bits [23:0] are left unchanged.
- R9: Pipe codes 0x84 and 0x86 carry no data. An accepted, non-faulting address write carrying either code raises `pipe_req` one cycle later with that code and `pipe_data` zero. Data writes to such an address are dropped and leave the address unchanged.
- R10: `stall` equals `pipe_req`. `pipe_req`, `pipe_code` and `pipe_data` hold steady until `pipe_done` is sampled high, after which `pipe_req` falls on the next cycle. Address and data writes presented while `stall` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_we | input | 1 | Address destination write strobe |
| addr_chk | input | 1 | 1 = user address, checked against protection table |
| addr_wdata | input | 32 | Address value written |
| data_we | input | 1 | Data destination write strobe |
| data_wdata | input | 32 | Data value written |
| pipe_done | input | 1 | Pipe write completion from the far side |
| reg_wr_valid | output | 1 | Register write strobe (one-cycle pulse) |
| reg_wr_addr | output | 18 | Register index of the write |
| reg_wr_data | output | 32 | Register write value |
| pipe_req | output | 1 | Pipe write pending |
| pipe_code | output | 8 | Pipe register code |
| pipe_data | output | 32 | Pipe write value (zero for no-data codes) |
| prot_fault | output | 1 | Latched user address missed the protection table |
| stall | output | 1 | Controller must hold off further writes |

## Verification
The properties assume that `pipe_done` has meaning only while `pipe_req` is high, and that code 0x84 is one of the no-data codes. They make no assumption about the controller obeying `stall`, because the port itself drops writes during a stall. The stimulus takes addresses from pools that hit each table entry and miss it, and that cover bit 18 and the wrap points in both spaces. It keeps writing while stalled and pulses `pipe_done` at random, so completion arrives both at once and after a delay.

// File: rtl/regwr_pkg.sv
// Shared constants for the register write port.
// Assumes the address word carries the register index in its low bits,
// the no-increment flag just above it, and the pipe code in the top byte.
package regwr_pkg;
    localparam int CODE_W    = 8;   // pipe code field width (top of address)
    localparam int REG_IDX_W = 18;  // register index width; next bit is no-increment
    localparam int WORD_W    = 32;  // default address / data width

    typedef enum logic {
        SPACE_REG  = 1'b0,
        SPACE_PIPE = 1'b1
    } space_e;
endpackage

// File: rtl/regwr_prot_match.sv
// Protection table lookup: flags a hit when any base/mask entry matches.
// Assumes the table is fixed at elaboration; purely combinational.
module regwr_prot_match #(
    parameter int AW = 32,
    parameter int N  = 4,
    parameter logic [N*AW-1:0] BASE = '0,
    parameter logic [N*AW-1:0] MASK = '0
) (
    input  logic [AW-1:0] addr,
    output logic          hit
);
    logic [N-1:0] entry_hit;

    // One comparator per table entry
    for (genvar i = 0; i < N; i++) begin : g_entry
        assign entry_hit[i] = ((addr & MASK[i*AW +: AW]) == BASE[i*AW +: AW]);
    end

    // Any entry grants access
    assign hit = |entry_hit;
endmodule

// File: rtl/regwr_addr_track.sv
// Latched address state: holds the target address, its valid flag and the
// protection fault, and presents the effective values for the current cycle
// (a same-cycle address write takes precedence over the latched state).
// Assumes `step` is only raised for an accepted data write.
module regwr_addr_track
    import regwr_pkg::*;
#(
    parameter int AW   = 32,
    parameter int RA_W = REG_IDX_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept,
    input  logic          addr_we,
    input  logic          addr_chk,
    input  logic [AW-1:0] addr_wdata,
    input  logic          prot_hit,
    input  logic          step,
    output logic [AW-1:0] eff_addr,
    output logic          eff_vld,
    output logic          eff_fault,
    output space_e        eff_space
);
    localparam int CODE_LSB = AW - CODE_W;

    logic [AW-1:0] lat_addr;
    logic          lat_vld;
    logic          lat_fault;
    logic [AW-1:0] next_addr;

    // Effective target for this cycle: new address wins over latched one
    always_comb begin
        eff_addr  = addr_we ? addr_wdata : lat_addr;
        eff_vld   = addr_we | lat_vld;
        eff_fault = addr_we ? (addr_chk & ~prot_hit) : lat_fault;
        eff_space = (|eff_addr[AW-1:CODE_LSB]) ? SPACE_PIPE : SPACE_REG;
    end

    // Advance the index field of the space being addressed
    always_comb begin
        next_addr = eff_addr;
        if (step) begin
            if (eff_space == SPACE_PIPE)
                next_addr[AW-1:CODE_LSB] = eff_addr[AW-1:CODE_LSB] + 1'b1;
            else
                next_addr[RA_W-1:0] = eff_addr[RA_W-1:0] + 1'b1;
        end
    end

    // Latch the effective state whenever the port is not stalled
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_addr  <= '0;
            lat_vld   <= 1'b0;
            lat_fault <= 1'b0;
        end else if (accept) begin
            lat_addr  <= next_addr;
            lat_vld   <= eff_vld;
            lat_fault <= eff_fault;
        end
    end
endmodule

// File: rtl/regwr_pipe_issue.sv
// Pipe write holder: captures one pipe command and keeps it on the bus
// until completion is reported. Assumes `issue` is never raised while busy.
module regwr_pipe_issue
    import regwr_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue,
    input  logic [CODE_W-1:0] code_in,
    input  logic [DW-1:0]     data_in,
    input  logic              done,
    output logic              req,
    output logic [CODE_W-1:0] code,
    output logic [DW-1:0]     data
);
    // Request flag: set on issue, cleared on completion
    always_ff @(posedge clk) begin
        if (!rst_n)
            req <= 1'b0;
        else if (req)
            req <= ~done;
        else
            req <= issue;
    end

    // Command payload: loaded on issue, held while pending
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code <= '0;
            data <= '0;
        end else if (!req && issue) begin
            code <= code_in;
            data <= data_in;
        end
    end
endmodule

// File: rtl/regwr_port.sv
// Register write address/data port. A controller writes an address
// destination (privileged or protection-checked) and a data destination;
// each data write becomes a register write or a pipe write.
// Assumes at most one address and one data write per cycle.
module regwr_port
    import regwr_pkg::*;
#(
    parameter int AW     = WORD_W,
    parameter int DW     = WORD_W,
    parameter int RA_W   = REG_IDX_W,
    parameter int PROT_N = 4,
    parameter logic [PROT_N*AW-1:0] PROT_BASE =
        {32'hA000_0000, 32'h0004_2000, 32'h0000_8000, 32'h0000_1000},
    parameter logic [PROT_N*AW-1:0] PROT_MASK =
        {32'hFF00_0000, 32'hFFFF_FF00, 32'hFFFF_FF00, 32'hFFFF_F000},
    parameter int ND_N = 2,
    parameter logic [ND_N*CODE_W-1:0] ND_CODES = {8'h86, 8'h84}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_we,
    input  logic              addr_chk,
    input  logic [AW-1:0]     addr_wdata,
    input  logic              data_we,
    input  logic [DW-1:0]     data_wdata,
    input  logic              pipe_done,
    output logic              reg_wr_valid,
    output logic [RA_W-1:0]   reg_wr_addr,
    output logic [DW-1:0]     reg_wr_data,
    output logic              pipe_req,
    output logic [CODE_W-1:0] pipe_code,
    output logic [DW-1:0]     pipe_data,
    output logic              prot_fault,
    output logic              stall
);
    localparam int NOINC_BIT = RA_W;
    localparam int CODE_LSB  = AW - CODE_W;

    logic              accept;
    logic              prot_hit;
    logic [AW-1:0]     eff_addr;
    logic              eff_vld;
    logic              eff_fault;
    space_e            eff_space;
    logic [CODE_W-1:0] eff_code;
    logic [ND_N-1:0]   nd_hits;
    logic              eff_nodata;
    logic              do_data;
    logic              fire_nodata;
    logic              step;
    logic              pipe_issue;
    logic [DW-1:0]     pipe_payload;
    logic              fault_q;

    assign accept = ~pipe_req;

    regwr_prot_match #(
        .AW(AW), .N(PROT_N), .BASE(PROT_BASE), .MASK(PROT_MASK)
    ) prot_i (
        .addr (addr_wdata),
        .hit  (prot_hit)
    );

    regwr_addr_track #(.AW(AW), .RA_W(RA_W)) track_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .addr_we    (addr_we),
        .addr_chk   (addr_chk),
        .addr_wdata (addr_wdata),
        .prot_hit   (prot_hit),
        .step       (step),
        .eff_addr   (eff_addr),
        .eff_vld    (eff_vld),
        .eff_fault  (eff_fault),
        .eff_space  (eff_space)
    );

    assign eff_code = eff_addr[AW-1:CODE_LSB];

    // One comparator per no-data pipe code
    for (genvar i = 0; i < ND_N; i++) begin : g_nodata
        assign nd_hits[i] = (eff_code == ND_CODES[i*CODE_W +: CODE_W]);
    end

    // Decide what this cycle's writes produce
    always_comb begin
        eff_nodata   = (eff_space == SPACE_PIPE) && (|nd_hits);
        do_data      = accept && data_we && eff_vld && !eff_fault && !eff_nodata;
        fire_nodata  = accept && addr_we && !eff_fault && eff_nodata;
        step         = do_data && !eff_addr[NOINC_BIT];
        pipe_issue   = fire_nodata || (do_data && (eff_space == SPACE_PIPE));
        pipe_payload = fire_nodata ? '0 : data_wdata;
    end

    regwr_pipe_issue #(.DW(DW)) pipe_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .issue   (pipe_issue),
        .code_in (eff_code),
        .data_in (pipe_payload),
        .done    (pipe_done),
        .req     (pipe_req),
        .code    (pipe_code),
        .data    (pipe_data)
    );

    // Register write bus: one-cycle strobe, payload held between writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_wr_valid <= 1'b0;
            reg_wr_addr  <= '0;
            reg_wr_data  <= '0;
        end else begin
            reg_wr_valid <= do_data && (eff_space == SPACE_REG);
            if (do_data && (eff_space == SPACE_REG)) begin
                reg_wr_addr <= eff_addr[RA_W-1:0];
                reg_wr_data <= data_wdata;
            end
        end
    end

    // Visible fault flag, refreshed on each accepted cycle
    always_ff @(posedge clk) begin
        if (!rst_n)
            fault_q <= 1'b0;
        else if (accept)
            fault_q <= eff_fault;
    end

    assign prot_fault = fault_q;
    assign stall      = pipe_req;
endmodule

// File: rtl/regwr_port_chk.sv
// Property checker for the register write port, bound to every instance.
// Keeps its own record of whether an address has been accepted since reset.
module regwr_port_chk #(
    parameter int AW   = 32,
    parameter int DW   = 32,
    parameter int RA_W = 18,
    parameter logic [7:0] PROBE_CODE = 8'h84
) (
    input logic            clk,
    input logic            rst_n,
    input logic            addr_we,
    input logic            addr_chk,
    input logic [AW-1:0]   addr_wdata,
    input logic            data_we,
    input logic            pipe_done,
    input logic            reg_wr_valid,
    input logic [RA_W-1:0] reg_wr_addr,
    input logic            pipe_req,
    input logic [7:0]      pipe_code,
    input logic [DW-1:0]   pipe_data,
    input logic            prot_fault,
    input logic            stall
);
    logic seen_q;

    // Tracks whether any address was accepted since reset
    always_ff @(posedge clk) begin
        if (!rst_n)
            seen_q <= 1'b0;
        else if (addr_we && !stall)
            seen_q <= 1'b1;
    end

    p_stall_ignores_r10: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> !reg_wr_valid);

    p_pipe_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pipe_req && !pipe_done) |=> (pipe_req && $stable(pipe_code) && $stable(pipe_data)));

    p_fault_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_fault && !addr_we && !stall) |=> !reg_wr_valid);

    p_priv_nofault_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_we && !addr_chk && !stall) |=> !prot_fault);

    p_nodata_fire_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_we && !addr_chk && !stall && addr_wdata[AW-1:AW-8] == PROBE_CODE)
        |=> (pipe_req && pipe_code == PROBE_CODE && pipe_data == '0));

    p_unlatched_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (data_we && !addr_we && !stall && !seen_q) |=> (!reg_wr_valid && !pipe_req));

    p_one_bus_r8: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_valid |-> !$rose(pipe_req));
endmodule

bind regwr_port regwr_port_chk #(.AW(AW), .DW(DW), .RA_W(RA_W)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .addr_we      (addr_we),
    .addr_chk     (addr_chk),
    .addr_wdata   (addr_wdata),
    .data_we      (data_we),
    .pipe_done    (pipe_done),
    .reg_wr_valid (reg_wr_valid),
    .reg_wr_addr  (reg_wr_addr),
    .pipe_req     (pipe_req),
    .pipe_code    (pipe_code),
    .pipe_data    (pipe_data),
    .prot_fault   (prot_fault),
    .stall        (stall)
);

// File: tb/regwr_port_tb_top.sv
// Bench for the register write port: directed corner cases then seeded
// random traffic, each cycle compared with a requirement-level model.
module regwr_port_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        addr_we = 1'b0;
    logic        addr_chk = 1'b0;
    logic [31:0] addr_wdata = '0;
    logic        data_we = 1'b0;
    logic [31:0] data_wdata = '0;
    logic        pipe_done = 1'b0;
    logic        reg_wr_valid;
    logic [17:0] reg_wr_addr;
    logic [31:0] reg_wr_data;
    logic        pipe_req;
    logic [7:0]  pipe_code;
    logic [31:0] pipe_data;
    logic        prot_fault;
    logic        stall;

    int checks = 0;
    int fails  = 0;

    // Model state
    logic [31:0] m_lat = '0;
    logic        m_vld = 1'b0;
    logic        m_fault = 1'b0;
    logic        m_req = 1'b0;
    logic [7:0]  m_code = '0;
    logic [31:0] m_pdata = '0;
    logic        m_rv = 1'b0;
    logic [17:0] m_ra = '0;
    logic [31:0] m_rd = '0;

    always #4 clk = ~clk;

    regwr_port dut_i (
        .clk(clk), .rst_n(rst_n),
        .addr_we(addr_we), .addr_chk(addr_chk), .addr_wdata(addr_wdata),
        .data_we(data_we), .data_wdata(data_wdata), .pipe_done(pipe_done),
        .reg_wr_valid(reg_wr_valid), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
        .pipe_req(pipe_req), .pipe_code(pipe_code), .pipe_data(pipe_data),
        .prot_fault(prot_fault), .stall(stall)
    );

    function automatic bit tbl_hit(logic [31:0] a);
        return ((a & 32'hFFFF_F000) == 32'h0000_1000) ||
               ((a & 32'hFFFF_FF00) == 32'h0000_8000) ||
               ((a & 32'hFFFF_FF00) == 32'h0004_2000) ||
               ((a & 32'hFF00_0000) == 32'hA000_0000);
    endfunction

    function automatic bit is_nodata(logic [31:0] a);
        return (a[31:24] == 8'h84) || (a[31:24] == 8'h86);
    endfunction

    function automatic logic [31:0] advance(logic [31:0] a);
        if (a[18])
            return a;
        if (a[31:24] != 0)
            return {a[31:24] + 8'd1, a[23:0]};
        return {a[31:18], a[17:0] + 18'd1};
    endfunction

    task automatic check(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Model one clock edge from the requirements
    task automatic model_step();
        logic [31:0] ea;
        logic ev, ef, pipe, nd, ok;
        m_rv = 1'b0;
        if (m_req) begin
            if (pipe_done) m_req = 1'b0;
        end else begin
            ea   = addr_we ? addr_wdata : m_lat;
            ev   = addr_we | m_vld;
            ef   = addr_we ? (addr_chk && !tbl_hit(addr_wdata)) : m_fault;
            pipe = (ea[31:24] != 0);
            nd   = pipe && is_nodata(ea);
            ok   = data_we && ev && !ef && !nd;
            if (ok && !pipe) begin
                m_rv = 1'b1; m_ra = ea[17:0]; m_rd = data_wdata;
            end
            if (ok && pipe) begin
                m_req = 1'b1; m_code = ea[31:24]; m_pdata = data_wdata;
            end
            if (addr_we && !ef && nd) begin
                m_req = 1'b1; m_code = ea[31:24]; m_pdata = '0;
            end
            m_lat   = ok ? advance(ea) : ea;
            m_vld   = ev;
            m_fault = ef;
        end
    endtask

    task automatic compare(string tag);
        check(reg_wr_valid == m_rv, tag, "reg_wr_valid", 64'(reg_wr_valid), 64'(m_rv));
        if (m_rv) begin
            check(reg_wr_addr == m_ra, tag, "reg_wr_addr", 64'(reg_wr_addr), 64'(m_ra));
            check(reg_wr_data == m_rd, tag, "reg_wr_data", 64'(reg_wr_data), 64'(m_rd));
        end
        check(pipe_req == m_req, tag, "pipe_req", 64'(pipe_req), 64'(m_req));
        check(stall == m_req, "R10", "stall", 64'(stall), 64'(m_req));
        if (m_req) begin
            check(pipe_code == m_code, tag, "pipe_code", 64'(pipe_code), 64'(m_code));
            check(pipe_data == m_pdata, tag, "pipe_data", 64'(pipe_data), 64'(m_pdata));
        end
        check(prot_fault == m_fault, tag, "prot_fault", 64'(prot_fault), 64'(m_fault));
    endtask

    // Drive one cycle at the falling edge, compare a cycle later
    task automatic cyc(bit aw, bit au, logic [31:0] ad, bit dw, logic [31:0] dd, bit done, string tag);
        addr_we = aw; addr_chk = au; addr_wdata = ad;
        data_we = dw; data_wdata = dd; pipe_done = done;
        @(posedge clk);
        model_step();
        @(negedge clk);
        addr_we = 1'b0; data_we = 1'b0; pipe_done = 1'b0;
        compare(tag);
    endtask

    function automatic logic [31:0] pick_addr(int unsigned r);
        case (r % 12)
            0:  return 32'h0000_1234;
            1:  return 32'h0000_80F0;
            2:  return 32'h0004_2010;
            3:  return 32'hA000_0000;
            4:  return 32'h0000_3000;
            5:  return 32'h8400_0000;
            6:  return 32'h0003_FFFF;
            7:  return 32'hA004_0000;
            8:  return 32'h8600_0000;
            9:  return 32'hFF00_0000;
            10: return 32'h0004_0010;
            default: return 32'h0000_0100;
        endcase
    endfunction

    // Watchdog: a hung run counts as a failure and still summarises
    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check(!reg_wr_valid && !pipe_req && !prot_fault && !stall, "R1", "outputs in reset",
              {60'd0, reg_wr_valid, pipe_req, prot_fault, stall}, 64'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R7: data before any address is dropped
        cyc(0, 0, 0, 1, 32'h1111_1111, 0, "R7");
        // R4: register writes with wrap of the index field
        cyc(1, 0, 32'h0003_FFFF, 0, 0, 0, "R2");
        cyc(0, 0, 0, 1, 32'hAAAA_0001, 0, "R4");
        cyc(0, 0, 0, 1, 32'hAAAA_0002, 0, "R4");
        // R5: bit 18 holds the address
        cyc(1, 0, 32'h0004_0010, 0, 0, 0, "R5");
        cyc(0, 0, 0, 1, 32'h5, 0, "R5");
        cyc(0, 0, 0, 1, 32'h6, 0, "R5");
        // R6: same-cycle address and data
        cyc(1, 0, 32'h0000_0200, 1, 32'h77, 0, "R6");
        cyc(0, 0, 0, 1, 32'h78, 0, "R6");
        // R3: user miss faults and blocks data; user hit works
        cyc(1, 1, 32'h0000_3000, 0, 0, 0, "R3");
        cyc(0, 0, 0, 1, 32'h99, 0, "R3");
        cyc(1, 1, 32'h0000_1234, 1, 32'h9A, 0, "R3");
        cyc(1, 1, 32'h0000_3000, 0, 0, 0, "R3");
        // R2: privileged address clears the fault
        cyc(1, 0, 32'h0000_3000, 1, 32'h9B, 0, "R2");
        // R8 / R10: pipe write, stall with ignored writes, completion
        cyc(1, 0, 32'hA000_0000, 1, 32'hC0DE, 0, "R8");
        cyc(0, 0, 0, 1, 32'hDEAD, 0, "R10");
        cyc(1, 0, 32'h0000_0400, 1, 32'hBEEF, 0, "R10");
        cyc(0, 0, 0, 0, 0, 1, "R10");
        cyc(0, 0, 0, 1, 32'hC0DF, 0, "R8");
        cyc(0, 0, 0, 0, 0, 1, "R8");
        // R9: no-data code fires on address write; data to it dropped
        cyc(1, 0, 32'h8400_0000, 1, 32'h1, 0, "R9");
        cyc(0, 0, 0, 0, 0, 1, "R9");
        cyc(0, 0, 0, 1, 32'h2, 0, "R9");
        cyc(1, 1, 32'h8600_0000, 0, 0, 0, "R9");

        // Seeded random traffic
        for (int i = 0; i < 4000; i++) begin
            int unsigned r = $urandom;
            cyc((r % 4) == 0, ((r >> 3) % 2) == 1, pick_addr($urandom),
                ((r >> 5) % 3) != 0, $urandom, ((r >> 8) % 3) == 0, "R4");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule